// File: doc/BRIEF.md
# Passive LCD Timing Generator

This block turns a stream of 4-bit pixel nibbles into the control waveforms of a passive-matrix LCD panel with a 4-bit, non-split data bus. Nibbles arrive on a valid/ready handshake. For each accepted nibble the block drives the data bus and raises the shift clock in the same cycle. The panel samples the data on the following falling edge of the shift clock.

Once a full line of nibbles has been shifted out, the block raises the line-latch pulse for a programmable number of clocks and holds the shift clock low during it. On the last line of the panel, the frame pulse rides on that line-latch pulse. An AC-drive polarity output toggles either once per frame or after a programmable number of line-latch pulses.

If no nibble is ready when one is due, the shift clock stalls and a sticky underflow flag is set. Dropping the enable darkens every panel output in the same cycle. The polarity output keeps its level while the block is disabled. The configuration inputs are expected to change only while the block is disabled.

Top module: `lcd_tgen`

## Requirements
- R1: After reset, with the enable low, `lcd_cp`, `lcd_load`, `lcd_frame`, `lcd_done`, `panel_on`, `underflow`, `lcd_df` and `lcd_data` are all 0.
- R2: The first clock after the enable rises is idle. After that, `px_ready` is high in each cycle where a nibble is due. When `px_valid` is also high in that cycle, the nibble appears on `lcd_data` in the next cycle and `lcd_cp` is high in that cycle. `lcd_cp` stays high for exactly one clock and is then low for at least one clock.
- R3: When a nibble is due and `px_valid` is low, `lcd_cp` does not pulse and `lcd_data` does not change. `underflow` rises in the next cycle and stays high until the block is disabled.
- R4: The clock after the `lcd_cp` pulse of the line's last nibble, `lcd_load` goes high. A line holds `cfg_line_len` nibbles, and a value of 0 counts as 1. `lcd_load` stays high for `cfg_load_w` clocks, where 0 counts as 1. `lcd_cp` is low for the whole pulse.
- R5: `lcd_frame` is high exactly during the `lcd_load` pulse of line number `cfg_lines` of each frame (0 counts as 1). It is low at every other time, including before the first `lcd_cp` of the next frame.
- R6: With `cfg_df_mode` = 0, `lcd_df` inverts in the clock after the last cycle of each frame's final `lcd_load` pulse.
- R7: With `cfg_df_mode` = 1, `lcd_df` inverts in the clock after the last cycle of every `cfg_df_loads`-th `lcd_load` pulse (0 counts as 1). The pulse count restarts at zero whenever the block is disabled.
- R8: While `disp_en` is low, `lcd_cp`, `lcd_load`, `lcd_frame` and `lcd_data` are 0 in that same cycle, and `lcd_df` keeps its level. Re-enabling starts at line 1 of a fresh frame.
- R9: `panel_on` is high when the block is enabled and past its idle first clock. `lcd_done` is high when the block is enabled and not in a line's shifting phase, that is, during `lcd_load` and the idle first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_en | input | 1 | Display enable |
| cfg_line_len | input | LEN_W | Nibbles per line |
| cfg_lines | input | LINES_W | Lines per frame |
| cfg_load_w | input | LOADW_W | Line-latch pulse width in clocks |
| cfg_df_mode | input | 1 | 0: polarity per frame, 1: per N latch pulses |
| cfg_df_loads | input | DFC_W | Latch pulses per polarity toggle in mode 1 |
| px_valid | input | 1 | Nibble available |
| px_data | input | 4 | Pixel nibble |
| px_ready | output | 1 | Nibble taken this cycle when valid |
| lcd_cp | output | 1 | Shift clock |
| lcd_load | output | 1 | Line-latch pulse |
| lcd_frame | output | 1 | Frame pulse |
| lcd_df | output | 1 | AC-drive polarity |
| lcd_data | output | 4 | Panel data bus |
| lcd_done | output | 1 | No video shifting |
| panel_on | output | 1 | Panel display-enable |
| underflow | output | 1 | Sticky starvation flag |

## Verification
The assertions assume that the configuration stays stable while `disp_en` is high and that `rst_n` is held for at least one clock at start-up. They make no assumption about `px_valid`, which may drop in any cycle. The stimulus changes configuration only during disabled stretches. It drives `px_valid` in three patterns, namely always high, high on every third clock and high on every other clock, so that both a steady stream and a starving one are seen. It also drops the enable part-way through a line and part-way through a latch pulse.

// File: rtl/lcd_tgen_pkg.sv
// Shared types for the passive LCD timing generator.
// Assumes nothing beyond the default parameter set of the top module.
package lcd_tgen_pkg;

    // Sequencer phases: idle after enable, shifting a line, latch pulse.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } lcd_st_e;

    localparam int unsigned NIB_W = 4;

endpackage

// File: rtl/lcd_tgen_hseq.sv
// Horizontal sequencer: takes nibbles over valid/ready, drives the data
// register and a one-clock shift-clock pulse per nibble, counts nibbles
// and flags the end of a line. Sets a sticky flag when starved.
// Assumes cfg_len is stable while enabled; a length of 0 behaves as 1.
module lcd_tgen_hseq #(
    parameter int unsigned LEN_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          shift_act,
    input  logic [LEN_W-1:0]              cfg_len,
    input  logic                          in_valid,
    input  logic [lcd_tgen_pkg::NIB_W-1:0] in_data,
    output logic                          in_ready,
    output logic                          cp_q,
    output logic [lcd_tgen_pkg::NIB_W-1:0] dat_q,
    output logic                          uf_q,
    output logic                          line_end
);

    logic             ph_q;   // 0: nibble due, 1: shift clock high
    logic [LEN_W-1:0] hcnt_q;

    // A nibble is requested only in the low half of a shift period.
    assign in_ready = shift_act && !ph_q;
    // The high half of the final nibble closes the line.
    assign line_end = shift_act && ph_q && (hcnt_q >= cfg_len);

    // Nibble handshake, shift-clock pulse, nibble count and underflow.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph_q   <= 1'b0;
            hcnt_q <= '0;
            cp_q   <= 1'b0;
            dat_q  <= '0;
            uf_q   <= 1'b0;
        end else if (shift_act) begin
            if (!ph_q) begin
                if (in_valid) begin
                    cp_q   <= 1'b1;
                    dat_q  <= in_data;
                    ph_q   <= 1'b1;
                    hcnt_q <= hcnt_q + 1'b1;
                end else begin
                    uf_q <= 1'b1;
                end
            end else begin
                cp_q <= 1'b0;
                ph_q <= 1'b0;
                if (line_end) begin
                    hcnt_q <= '0;
                end
            end
        end else begin
            cp_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lcd_tgen_vseq.sv
// Vertical sequencer: phase state machine, latch-pulse width timer and
// line counter. Reports the last cycle of each latch pulse and whether
// the current line is the last of the frame.
// Assumes configuration is stable while enabled; zero widths act as 1.
module lcd_tgen_vseq #(
    parameter int unsigned LINES_W = 9,
    parameter int unsigned LOADW_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  line_end,
    input  logic [LINES_W-1:0]    cfg_lines,
    input  logic [LOADW_W-1:0]    cfg_load_w,
    output lcd_tgen_pkg::lcd_st_e st_q,
    output logic                  load_end,
    output logic                  last_line
);
    import lcd_tgen_pkg::*;

    logic [LOADW_W-1:0] lcnt_q;
    logic [LINES_W-1:0] vcnt_q;

    // Last line when the 1-based line number reaches the programmed count.
    assign last_line = ({1'b0, vcnt_q} + 1'b1) >= {1'b0, cfg_lines};
    // The pulse ends once it has lasted the programmed number of clocks.
    assign load_end  = (st_q == ST_LOAD) && (lcnt_q >= cfg_load_w);

    // Phase transitions, pulse timer and line counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st_q   <= ST_IDLE;
            lcnt_q <= '0;
            vcnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: st_q <= ST_SHIFT;
                ST_SHIFT: begin
                    if (line_end) begin
                        st_q   <= ST_LOAD;
                        lcnt_q <= {{(LOADW_W-1){1'b0}}, 1'b1};
                    end
                end
                ST_LOAD: begin
                    if (load_end) begin
                        st_q   <= ST_SHIFT;
                        lcnt_q <= '0;
                        vcnt_q <= last_line ? '0 : vcnt_q + 1'b1;
                    end else begin
                        lcnt_q <= lcnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_tgen_df.sv
// AC-drive polarity generator: inverts once per frame, or after a
// programmable number of latch pulses. Holds its level while disabled;
// the pulse count restarts when disabled. A count of 0 acts as 1.
module lcd_tgen_df #(
    parameter int unsigned DFC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load_end,
    input  logic             last_line,
    input  logic             cfg_mode,
    input  logic [DFC_W-1:0] cfg_loads,
    output logic             df_q
);

    logic [DFC_W-1:0] cnt_q;
    logic             cnt_hit;

    // The pulse now ending completes the programmed group.
    assign cnt_hit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cfg_loads};

    // Polarity toggle and latch-pulse counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            df_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (load_end) begin
            if (!cfg_mode) begin
                if (last_line) begin
                    df_q <= ~df_q;
                end
            end else if (cnt_hit) begin
                df_q  <= ~df_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_tgen.sv
// Passive LCD timing generator top: joins the horizontal and vertical
// sequencers and the polarity generator and gates panel outputs with the
// enable. Assumes configuration changes only while disp_en is low.
module lcd_tgen #(
    parameter int unsigned LEN_W   = 10,
    parameter int unsigned LINES_W = 9,
    parameter int unsigned LOADW_W = 4,
    parameter int unsigned DFC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_en,
    input  logic [LEN_W-1:0]   cfg_line_len,
    input  logic [LINES_W-1:0] cfg_lines,
    input  logic [LOADW_W-1:0] cfg_load_w,
    input  logic               cfg_df_mode,
    input  logic [DFC_W-1:0]   cfg_df_loads,
    input  logic               px_valid,
    input  logic [3:0]         px_data,
    output logic               px_ready,
    output logic               lcd_cp,
    output logic               lcd_load,
    output logic               lcd_frame,
    output logic               lcd_df,
    output logic [3:0]         lcd_data,
    output logic               lcd_done,
    output logic               panel_on,
    output logic               underflow
);
    import lcd_tgen_pkg::*;

    lcd_st_e    st;
    logic       shift_act;
    logic       line_end;
    logic       load_end;
    logic       last_line;
    logic       cp_q;
    logic [3:0] dat_q;

    assign shift_act = disp_en && (st == ST_SHIFT);

    lcd_tgen_hseq #(.LEN_W(LEN_W)) u_hseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (disp_en),
        .shift_act (shift_act),
        .cfg_len   (cfg_line_len),
        .in_valid  (px_valid),
        .in_data   (px_data),
        .in_ready  (px_ready),
        .cp_q      (cp_q),
        .dat_q     (dat_q),
        .uf_q      (underflow),
        .line_end  (line_end)
    );

    lcd_tgen_vseq #(.LINES_W(LINES_W), .LOADW_W(LOADW_W)) u_vseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (disp_en),
        .line_end   (line_end),
        .cfg_lines  (cfg_lines),
        .cfg_load_w (cfg_load_w),
        .st_q       (st),
        .load_end   (load_end),
        .last_line  (last_line)
    );

    lcd_tgen_df #(.DFC_W(DFC_W)) u_df (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (disp_en),
        .load_end  (load_end),
        .last_line (last_line),
        .cfg_mode  (cfg_df_mode),
        .cfg_loads (cfg_df_loads),
        .df_q      (lcd_df)
    );

    // Panel outputs go dark in the same cycle the enable drops.
    assign lcd_cp    = disp_en && cp_q;
    assign lcd_load  = disp_en && (st == ST_LOAD);
    assign lcd_frame = lcd_load && last_line;
    assign lcd_data  = disp_en ? dat_q : 4'd0;
    assign lcd_done  = disp_en && (st != ST_SHIFT);
    assign panel_on  = disp_en && (st != ST_IDLE);

endmodule

// File: rtl/lcd_tgen_chk.sv
// Property checker for the LCD timing generator, bound to every instance.
// Assumes rst_n is low for at least one clock at start-up.
module lcd_tgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       disp_en,
    input logic       px_valid,
    input logic       px_ready,
    input logic       lcd_cp,
    input logic       lcd_load,
    input logic       lcd_frame,
    input logic       lcd_df,
    input logic [3:0] lcd_data,
    input logic       underflow
);

    // R4: no shift clock during a latch pulse.
    a_r4_cp_quiet_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_load |-> !lcd_cp);

    // R5: frame pulse only on a latch pulse.
    a_r5_frame_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_frame |-> lcd_load);

    // R2: shift clock is a single-clock pulse.
    a_r2_cp_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cp |=> !lcd_cp);

    // R2: every shift clock follows an accepted nibble.
    a_r2_cp_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cp) |-> $past(px_valid && px_ready));

    // R3: underflow rises only after a due nibble was missing.
    a_r3_uf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(px_ready && !px_valid));

    // R8: panel outputs dark while disabled.
    a_r8_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (!lcd_cp && !lcd_load && !lcd_frame && lcd_data == 4'd0));

    // R6 / R7: polarity moves only right after a latch pulse.
    a_r6_df_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_df != $past(lcd_df)) |-> $past(lcd_load));

endmodule

bind lcd_tgen lcd_tgen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .disp_en   (disp_en),
    .px_valid  (px_valid),
    .px_ready  (px_ready),
    .lcd_cp    (lcd_cp),
    .lcd_load  (lcd_load),
    .lcd_frame (lcd_frame),
    .lcd_df    (lcd_df),
    .lcd_data  (lcd_data),
    .underflow (underflow)
);

// File: tb/lcd_tgen_tb_top.sv
// Bench: behavioural reference model compared with the design every clock.
module lcd_tgen_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n = 1'b0;
    logic       disp_en = 1'b0;
    logic [9:0] cfg_line_len = 10'd4;
    logic [8:0] cfg_lines = 9'd3;
    logic [3:0] cfg_load_w = 4'd2;
    logic       cfg_df_mode = 1'b0;
    logic [7:0] cfg_df_loads = 8'd1;
    logic       px_valid = 1'b0;
    logic [3:0] px_data = 4'd0;
    logic       px_ready, lcd_cp, lcd_load, lcd_frame, lcd_df;
    logic [3:0] lcd_data;
    logic       lcd_done, panel_on, underflow;

    lcd_tgen dut_i (
        .clk(clk), .rst_n(rst_n), .disp_en(disp_en),
        .cfg_line_len(cfg_line_len), .cfg_lines(cfg_lines),
        .cfg_load_w(cfg_load_w), .cfg_df_mode(cfg_df_mode),
        .cfg_df_loads(cfg_df_loads), .px_valid(px_valid), .px_data(px_data),
        .px_ready(px_ready), .lcd_cp(lcd_cp), .lcd_load(lcd_load),
        .lcd_frame(lcd_frame), .lcd_df(lcd_df), .lcd_data(lcd_data),
        .lcd_done(lcd_done), .panel_on(panel_on), .underflow(underflow)
    );

    // Reference model state: phase (0 idle, 1 line data, 2 latch), etc.
    int phase = 0, half = 0, taken = 0, pulse_age = 0, line_no = 0;
    int m_cp = 0, m_dat = 0, m_uf = 0, m_df = 0, group = 0;
    int vectors = 0, errors = 0, cyc = 0, nib = 0, pat = 0;
    bit init_chk = 1'b0;
    bit done_flag = 1'b0;

    task automatic cmp(input string req, input string nm, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    function automatic int at_least1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Expected outputs from model state and present inputs.
    task automatic check_all();
        int en_i;
        string rd, rp;
        en_i = int'(disp_en);
        rd = init_chk ? "R1" : (en_i == 0 ? "R8" : "R2");
        rp = init_chk ? "R1" : (cfg_df_mode ? "R7" : "R6");
        cmp(rd, "lcd_cp", int'(lcd_cp), en_i & m_cp);
        cmp(rd, "lcd_data", int'(lcd_data), en_i ? m_dat : 0);
        cmp(init_chk ? "R1" : (en_i == 0 ? "R8" : "R4"), "lcd_load", int'(lcd_load),
            (en_i == 1 && phase == 2) ? 1 : 0);
        cmp(init_chk ? "R1" : (en_i == 0 ? "R8" : "R5"), "lcd_frame", int'(lcd_frame),
            (en_i == 1 && phase == 2 && line_no + 1 >= at_least1(int'(cfg_lines))) ? 1 : 0);
        cmp(init_chk ? "R1" : "R2", "px_ready", int'(px_ready),
            (en_i == 1 && phase == 1 && half == 0) ? 1 : 0);
        cmp(init_chk ? "R1" : "R3", "underflow", int'(underflow), m_uf);
        cmp(rp, "lcd_df", int'(lcd_df), m_df);
        cmp(init_chk ? "R1" : "R9", "lcd_done", int'(lcd_done),
            (en_i == 1 && phase != 1) ? 1 : 0);
        cmp(init_chk ? "R1" : "R9", "panel_on", int'(panel_on),
            (en_i == 1 && phase != 0) ? 1 : 0);
    endtask

    // Advance the model by one clock.
    task automatic model_update();
        if (!rst_n) begin
            phase = 0; half = 0; taken = 0; pulse_age = 0; line_no = 0;
            m_cp = 0; m_dat = 0; m_uf = 0; m_df = 0; group = 0;
        end else if (!disp_en) begin
            phase = 0; half = 0; taken = 0; pulse_age = 0; line_no = 0;
            m_cp = 0; m_dat = 0; m_uf = 0; group = 0;
        end else if (phase == 0) begin
            phase = 1;
        end else if (phase == 1) begin
            if (half == 0) begin
                if (px_valid) begin
                    m_cp = 1; m_dat = int'(px_data); half = 1; taken++; nib++;
                end else begin
                    m_uf = 1;
                end
            end else begin
                m_cp = 0; half = 0;
                if (taken >= at_least1(int'(cfg_line_len))) begin
                    taken = 0; phase = 2; pulse_age = 1;
                end
            end
        end else begin
            m_cp = 0;
            if (pulse_age >= at_least1(int'(cfg_load_w))) begin
                phase = 1; pulse_age = 0;
                if (!cfg_df_mode) begin
                    if (line_no + 1 >= at_least1(int'(cfg_lines))) m_df ^= 1;
                end else if (group + 1 >= at_least1(int'(cfg_df_loads))) begin
                    m_df ^= 1; group = 0;
                end else begin
                    group++;
                end
                line_no = (line_no + 1 >= at_least1(int'(cfg_lines))) ? 0 : line_no + 1;
            end else begin
                pulse_age++;
            end
        end
    endtask

    // One clock: drive inputs at the falling edge, check, then advance.
    task automatic step(input bit do_chk);
        case (pat)
            0: px_valid = 1'b1;
            1: px_valid = (cyc % 3 == 0);
            default: px_valid = (cyc % 2 == 1);
        endcase
        px_data = 4'(nib);
        #1;
        if (do_chk) check_all();
        @(posedge clk);
        model_update();
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        end
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b0);
        rst_n = 1'b1;
        // R1: quiet state after reset, enable still low.
        init_chk = 1'b1;
        run(3);
        init_chk = 1'b0;
        // R2 R4 R5 R6: steady stream, per-frame polarity.
        disp_en = 1'b1; pat = 0;
        run(130);
        // R3: starving stream, every third clock.
        pat = 1;
        run(110);
        // R8: disable part-way through.
        disp_en = 1'b0;
        run(5);
        // R7: polarity after every second latch pulse, 1-nibble lines.
        cfg_df_mode = 1'b1; cfg_df_loads = 8'd2; cfg_line_len = 10'd1;
        cfg_lines = 9'd5; cfg_load_w = 4'd1; pat = 0;
        disp_en = 1'b1;
        run(90);
        disp_en = 1'b0;
        run(4);
        // R4 R5 R6: single-line frames, wide latch, alternating supply.
        cfg_df_mode = 1'b0; cfg_line_len = 10'd3; cfg_lines = 9'd1;
        cfg_load_w = 4'd3; pat = 2;
        disp_en = 1'b1;
        run(63);
        // R8: drop enable inside a latch pulse if one is under way.
        disp_en = 1'b0;
        run(4);
        // R7: zero counts behave as one.
        cfg_df_mode = 1'b1; cfg_df_loads = 8'd0; cfg_line_len = 10'd0;
        cfg_lines = 9'd0; cfg_load_w = 4'd0; pat = 0;
        disp_en = 1'b1;
        run(40);
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

endmodule